// File: doc/BRIEF.md
# Multichip Sync Clock Divider

This block divides the system clock by four to produce a sync clock that paces external control timing. On its own (master) the divide-by-four sequence runs freely. When several devices must share one phase, a slave device receives the master's sync clock on its sync input, detects the rising edge, and reloads its own divider so that both sync clocks run in step. Skew that is already present between the system clock edges of the devices is not removed.

A four-state machine holds the divider phase. Its states are `SC_PH0` and `SC_PH1`, in which the sync clock is high, and `SC_PH2` and `SC_PH3`, in which it is low. The transition ADVANCE moves `SC_PH0`→`SC_PH1`→`SC_PH2`→`SC_PH3`→`SC_PH0` on every system clock. The transition REALIGN, taken from any state when a slave sees a sync edge, loads `SC_PH0` in normal mode or `SC_PH1` in fast mode. Fast mode adds one register to the sync input path for sync clocks of 50 MHz and above. The one-count offset keeps the resulting phase the same as in normal mode.

An external update request is sampled only on rising edges of the sync clock. A newly seen high level yields a single system-clock-wide internal update pulse.

Top module: `sync_clkdiv`

## Requirements
- R1: While `rst_n` is low, `sync_clk_o` and `upd_pulse_o` are low. The state machine resets to `SC_PH3`.
- R2: With no realignment, `sync_clk_o` is high for two system clocks and low for two, period four. It is first high in the cycle after the first clock edge following reset release.
- R3: With `slave_en` low, edges on `sync_in` leave the `sync_clk_o` sequence unchanged.
- R4: Normal mode (`fast_sync`=0, `slave_en`=1): a rising `sync_in` captured at clock edge k makes the cycle after edge k+1 the first high cycle (`SC_PH0`) of the sync clock. Counting then continues from there.
- R5: Fast mode (`fast_sync`=1, `slave_en`=1): a rising `sync_in` captured at edge k leaves edge k+1 a plain ADVANCE. The cycle after edge k+2 is the second high cycle (`SC_PH1`), which is the same phase R4 gives.
- R6: Only a rising edge of `sync_in` realigns. Holding it high or dropping it leaves the sequence unchanged.
- R7: `upd_req` is sampled at every clock edge where `sync_clk_o` goes from low to high, including rises caused by REALIGN. `upd_pulse_o` is high in the cycle after such an edge exactly when the sample there is 1 and the previous sample was 0.
- R8: `upd_pulse_o` is never high for two cycles in a row. Changes of `upd_req` between sampling edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_en | input | 1 | 1: realign the divider to `sync_in` |
| fast_sync | input | 1 | 1: extra input stage with one-count compensation |
| sync_in | input | 1 | Sync clock from a master device |
| upd_req | input | 1 | External update request |
| sync_clk_o | output | 1 | System clock divided by four |
| upd_pulse_o | output | 1 | One-cycle internal update pulse |

## Verification
Two functions can fall in the same cycle: REALIGN can create a sync clock rise, and update sampling happens on that rise. In normal slave mode the bench raises `upd_req` together with `sync_in` at each of the four divider phases. In one of those cases the reload coincides with a natural rise, and in another it forces an early rise. The bench computes the phase arithmetically, treats every low-to-high change of its own phase as a sampling edge, and expects exactly one pulse per new request, with no pulse lost or duplicated when the reload and the natural rise coincide.

// File: rtl/sync_pkg.sv
package sync_pkg;
    localparam int PH_W = 2;
    typedef enum logic [PH_W-1:0] {
        SC_PH0 = 2'd0,
        SC_PH1 = 2'd1,
        SC_PH2 = 2'd2,
        SC_PH3 = 2'd3
    } ph_e;
    localparam ph_e RESET_PH = SC_PH3;
endpackage

// File: rtl/sync_in_sampler.sv
module sync_in_sampler #(
    parameter int SYNC_DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sync,
    input  logic sync_in,
    output logic edge_o
);
    localparam int CHAIN_W = SYNC_DEPTH + 2;

    logic [CHAIN_W-1:0] chain;
    logic               edge_norm;
    logic               edge_fast;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], sync_in};
    end

    assign edge_norm = chain[SYNC_DEPTH-1] & ~chain[SYNC_DEPTH];
    assign edge_fast = chain[SYNC_DEPTH]   & ~chain[SYNC_DEPTH+1];
    assign edge_o    = fast_sync ? edge_fast : edge_norm;

    // R6: a single rising edge yields a single detection
    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(fast_sync)) |=> !edge_o);
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic realign_i,
    input  logic fast_i,
    output logic sync_clk_o,
    output logic rise_o
);
    ph_e state, nxt;
    logic cur_hi, nxt_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RESET_PH;
        else        state <= nxt;
    end

    always_comb begin
        if (realign_i) begin
            nxt = fast_i ? SC_PH1 : SC_PH0;
        end else begin
            unique case (state)
                SC_PH0: nxt = SC_PH1;
                SC_PH1: nxt = SC_PH2;
                SC_PH2: nxt = SC_PH3;
                SC_PH3: nxt = SC_PH0;
                default: nxt = SC_PH0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            SC_PH0, SC_PH1: cur_hi = 1'b1;
            SC_PH2, SC_PH3: cur_hi = 1'b0;
            default:        cur_hi = 1'b0;
        endcase
        nxt_hi     = (nxt == SC_PH0) || (nxt == SC_PH1);
        sync_clk_o = cur_hi;
        rise_o     = nxt_hi && !cur_hi;
    end

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !realign_i |=> (2'(state) == 2'(2'($past(state)) + 2'd1)));
    assert_realign_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_i && !fast_i) |=> (state == SC_PH0));
    assert_realign_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_i && fast_i) |=> (state == SC_PH1));
endmodule

// File: rtl/upd_pulse_gen.sv
module upd_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic req_i,
    output logic pulse_o
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            pulse_o <= 1'b0;
        end else if (sample_i) begin
            req_q   <= req_i;
            pulse_o <= req_i & ~req_q;
        end else begin
            pulse_o <= 1'b0;
        end
    end

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(sample_i));
endmodule

// File: rtl/sync_clkdiv.sv
module sync_clkdiv #(
    parameter int SYNC_DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_en,
    input  logic fast_sync,
    input  logic sync_in,
    input  logic upd_req,
    output logic sync_clk_o,
    output logic upd_pulse_o
);
    logic edge_w;
    logic realign_w;
    logic rise_w;

    sync_in_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_samp (
        .clk(clk), .rst_n(rst_n), .fast_sync(fast_sync),
        .sync_in(sync_in), .edge_o(edge_w)
    );

    assign realign_w = edge_w & slave_en;

    phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .realign_i(realign_w), .fast_i(fast_sync),
        .sync_clk_o(sync_clk_o), .rise_o(rise_w)
    );

    upd_pulse_gen u_upd (
        .clk(clk), .rst_n(rst_n), .sample_i(rise_w),
        .req_i(upd_req), .pulse_o(upd_pulse_o)
    );

    // R7: a pulse appears only in the first cycle of a high sync clock
    assert_pulse_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |-> (sync_clk_o && !$past(sync_clk_o)));
endmodule

// File: tb/sim_sync_clkdiv.sv
module sim_sync_clkdiv;
    logic clk = 1'b0;
    logic rst_n, slave_en, fast_sync, sync_in, upd_req;
    logic sync_clk_o, upd_pulse_o;
    int checks = 0;
    int errors = 0;
    int ph;
    logic last_s;
    logic exp_p;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_clkdiv u0 (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .fast_sync(fast_sync),
        .sync_in(sync_in), .upd_req(upd_req),
        .sync_clk_o(sync_clk_o), .upd_pulse_o(upd_pulse_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one clock; forced >= 0 overrides the phase the bench expects
    task automatic step(input string ctag, input string ptag, input int forced);
        logic req_e;
        int   old;
        logic rise;
        req_e = upd_req;
        old   = ph;
        @(posedge clk); #1;
        ph    = (forced >= 0) ? forced : (ph + 1) % 4;
        rise  = (ph < 2) && (old >= 2);
        exp_p = rise && req_e && !last_s;
        if (rise) last_s = req_e;
        chk(ctag, sync_clk_o, ph < 2);
        chk(ptag, upd_pulse_o, exp_p);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; slave_en = 0; fast_sync = 0; sync_in = 0; upd_req = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sync_clk in reset", sync_clk_o, 1'b0);
        chk("R1 pulse in reset", upd_pulse_o, 1'b0);
        rst_n = 1; ph = 3; last_s = 0;

        // R2: free running divide by four
        for (int i = 0; i < 12; i++) step("R2", "R7", -1);

        // R3: master ignores sync_in at every phase
        for (int off = 0; off < 4; off++) begin
            for (int i = 0; i < off; i++) step("R3", "R7", -1);
            sync_in = 1;
            for (int i = 0; i < 6; i++) step("R3", "R7", -1);
            sync_in = 0;
            for (int i = 0; i < 5; i++) step("R3", "R7", -1);
        end

        // R4 with coincident update requests, all four phases
        slave_en = 1; fast_sync = 0;
        for (int off = 0; off < 4; off++) begin
            for (int i = 0; i < off; i++) step("R4", "R7", -1);
            sync_in = 1; upd_req = 1;
            step("R4", "R7", -1);   // edge k captures sync_in
            step("R4", "R7", 0);    // edge k+1 reloads SC_PH0
            for (int i = 0; i < 7; i++) step("R6 held high", "R7", -1);
            sync_in = 0; upd_req = 0;
            for (int i = 0; i < 6; i++) step("R6 falling", "R7", -1);
        end

        // R5: fast mode, same resulting phase one clock later
        fast_sync = 1;
        for (int off = 0; off < 4; off++) begin
            for (int i = 0; i < 3; i++) step("R5", "R7", -1);
            for (int i = 0; i < off; i++) step("R5", "R7", -1);
            sync_in = 1;
            step("R5", "R7", -1);   // edge k
            step("R5", "R7", -1);   // edge k+1 plain advance
            step("R5", "R7", 1);    // edge k+2 reloads SC_PH1
            for (int i = 0; i < 7; i++) step("R6 fast held", "R7", -1);
            sync_in = 0;
            for (int i = 0; i < 6; i++) step("R6 fast falling", "R7", -1);
        end

        // R8: request widths and offsets, changes between samples ignored
        slave_en = 0; fast_sync = 0;
        for (int off = 0; off < 4; off++) begin
            for (int w = 1; w <= 5; w++) begin
                for (int i = 0; i < off; i++) step("R2", "R8", -1);
                upd_req = 1;
                for (int i = 0; i < w; i++) step("R2", "R8", -1);
                upd_req = 0;
                for (int i = 0; i < 8; i++) step("R2", "R8", -1);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule